// File: doc/BRIEF.md
# Receive Special Character Detector

This block sits in a UART receive path between the deserializer and the receive FIFO. Each completed byte arrives as a one-cycle strobe with its data and an error flag. The block compares the byte against four programmable match characters: two "resume" characters and two "pause" characters. It then decides whether the byte is passed on to the FIFO.

A single register has two jobs. It is the second pause character, and it is also the special character that raises a status bit. The 2-bit flow mode chooses which pair of characters is used for flow control. Flow characters are swallowed rather than stored. So a byte equal to the second pause character is stored when the second pair is not in use, and swallowed when it is.

Status bits stay set until software reads the interrupt status. Each interrupt request is its status bit gated by its enable.

Top module: `uart_rx_char_match`

## Requirements
- R1: After reset, all four match characters are 0x00, and no FIFO write, status bit, pause state or interrupt is active.
- R2: A register write with address 0 sets resume character A, 1 sets resume character B, 2 sets pause character A, and 3 sets pause character B. The new value applies to bytes received from the next cycle on.
- R3: `fifo_wr` pulses, with `fifo_wdata` equal to the received byte, exactly one cycle after each `rx_valid` whose byte is not swallowed. It is low in every other cycle.
- R4: While `spec_en` is 0, no received byte sets `spec_flag`.
- R5: While `spec_en` is 1, a byte equal to pause character B sets `spec_flag` one cycle later. Bit 0 of the register is compared with the first-received data bit. In flow modes 00, 10 and 11 the byte is still written to the FIFO.
- R6: In flow mode 10, a byte equal to pause character A sets `xoff_state` and `xoff_flag`, and a byte equal to resume character A clears `xoff_state`. Neither byte is written to the FIFO. Special character detection works unchanged.
- R7: In flow mode 01, a byte equal to pause character B is not written to the FIFO. It sets `xoff_state` and `xoff_flag`, and it also sets `spec_flag` when `spec_en` is 1.
- R8: In flow mode 01, a byte equal to resume character B clears `xoff_state` and is not written to the FIFO.
- R9: A byte received with `rx_err` high never matches any character. It is always written to the FIFO.
- R10: `irq_spec` equals `spec_flag` AND `ie_spec`, and `irq_xoff` equals `xoff_flag` AND `ie_xoff`, within the same cycle.
- R11: `isr_rd` clears `spec_flag` and `xoff_flag` one cycle later. If a new match sets a flag in the same cycle as the read, the flag stays set.
- R12: When a byte equals both the active resume character and the active pause character, it acts as a pause character. Flow modes 00 and 11 compare no flow characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe for a completed received byte |
| rx_data | input | DW | Received byte, bit 0 received first |
| rx_err | input | 1 | Parity or framing error on this byte |
| spec_en | input | 1 | Special character detect enable |
| flow_mode | input | 2 | 00 none, 10 pair A, 01 pair B, 11 none |
| ie_spec | input | 1 | Special character interrupt enable |
| ie_xoff | input | 1 | Pause interrupt enable |
| reg_we | input | 1 | Match character write strobe |
| reg_addr | input | 2 | 0 resume A, 1 resume B, 2 pause A, 3 pause B |
| reg_wdata | input | DW | Match character write data |
| isr_rd | input | 1 | Interrupt status read; clears status bits |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_wdata | output | DW | Byte to the receive FIFO |
| spec_flag | output | 1 | Special character detected status |
| xoff_flag | output | 1 | Pause character received status |
| xoff_state | output | 1 | Remote transmitter paused |
| irq_spec | output | 1 | Special character interrupt request |
| irq_xoff | output | 1 | Pause interrupt request |

## Verification
Every registered result appears exactly one clock after the byte strobe, register write or status read that causes it. This covers the FIFO strobe and data, both status bits and the pause state. The interrupt requests follow their status bits and enables in the same cycle.

The bench drives inputs just after a rising edge. Before the next edge it advances a bench-side model from those inputs. One time unit after that edge it compares every output against the model. Every comparison therefore falls in the single cycle where the result is due. A missing or late pulse shows up as a mismatch.

// File: rtl/uart_rx_char_match.sv
module uart_rx_char_match #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_err,
  input  logic          spec_en,
  input  logic [1:0]    flow_mode,
  input  logic          ie_spec,
  input  logic          ie_xoff,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          isr_rd,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_wdata,
  output logic          spec_flag,
  output logic          xoff_flag,
  output logic          xoff_state,
  output logic          irq_spec,
  output logic          irq_xoff
);
  localparam int NCHR = 4;
  localparam logic [1:0] A_XON1 = 2'd0, A_XON2 = 2'd1, A_XOFF1 = 2'd2, A_XOFF2 = 2'd3;

  logic [DW-1:0] chr_q [NCHR];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NCHR; i++) chr_q[i] <= '0;
    end else if (reg_we) begin
      chr_q[reg_addr] <= reg_wdata;
    end

  logic good, pair_a, pair_b, hit_xoff, hit_xon, hit_spec, swallow;

  assign good     = rx_valid && !rx_err;
  assign pair_a   = flow_mode == 2'b10;
  assign pair_b   = flow_mode == 2'b01;
  assign hit_xoff = good && ((pair_a && rx_data == chr_q[A_XOFF1]) ||
                             (pair_b && rx_data == chr_q[A_XOFF2]));
  assign hit_xon  = good && !hit_xoff &&
                    ((pair_a && rx_data == chr_q[A_XON1]) ||
                     (pair_b && rx_data == chr_q[A_XON2]));
  assign hit_spec = good && spec_en && rx_data == chr_q[A_XOFF2];
  assign swallow  = hit_xoff || hit_xon;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
      spec_flag  <= 1'b0;
      xoff_flag  <= 1'b0;
      xoff_state <= 1'b0;
    end else begin
      fifo_wr <= rx_valid && !swallow;
      if (rx_valid) fifo_wdata <= rx_data;
      spec_flag <= hit_spec || (spec_flag && !isr_rd);
      xoff_flag <= hit_xoff || (xoff_flag && !isr_rd);
      if (hit_xoff)     xoff_state <= 1'b1;
      else if (hit_xon) xoff_state <= 1'b0;
    end

  assign irq_spec = spec_flag && ie_spec;
  assign irq_xoff = xoff_flag && ie_xoff;

  assert_idle_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !fifo_wr);
  assert_err_stored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_err) |=> (fifo_wr && fifo_wdata == $past(rx_data)));
  assert_spec_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!spec_en && !spec_flag) |=> !spec_flag);
  assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !rx_valid) |=> (!spec_flag && !xoff_flag));
  assert_pair_b_swallow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_err && flow_mode == 2'b01 && rx_data == chr_q[A_XOFF2])
      |=> (!fifo_wr && xoff_state && xoff_flag));
  assert_state_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(xoff_state));
endmodule

// File: tb/uart_rx_char_match_tb.sv
module uart_rx_char_match_tb;
  localparam int PERIOD = 10;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_err = 0, spec_en = 0, ie_spec = 0, ie_xoff = 0;
  logic [DW-1:0] rx_data = 0, reg_wdata = 0;
  logic [1:0] flow_mode = 0, reg_addr = 0;
  logic reg_we = 0, isr_rd = 0;
  logic fifo_wr, spec_flag, xoff_flag, xoff_state, irq_spec, irq_xoff;
  logic [DW-1:0] fifo_wdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [DW-1:0] m_chr [4];
  logic m_wr, m_spec, m_xflag, m_xstate;
  logic [DW-1:0] m_wdata;

  always #(PERIOD/2) clk = ~clk;

  uart_rx_char_match #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .spec_en(spec_en), .flow_mode(flow_mode), .ie_spec(ie_spec), .ie_xoff(ie_xoff),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .isr_rd(isr_rd),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .spec_flag(spec_flag),
    .xoff_flag(xoff_flag), .xoff_state(xoff_state), .irq_spec(irq_spec), .irq_xoff(irq_xoff));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_pause(logic [1:0] m, logic [DW-1:0] d);
    return (m == 2'b10 && d == m_chr[2]) || (m == 2'b01 && d == m_chr[3]);
  endfunction

  function automatic bit is_resume(logic [1:0] m, logic [DW-1:0] d);
    return (m == 2'b10 && d == m_chr[0]) || (m == 2'b01 && d == m_chr[1]);
  endfunction

  task automatic tick();
    bit ok, pz, rs, sp;
    ok = rx_valid && !rx_err;                       // R9
    pz = ok && is_pause(flow_mode, rx_data);        // R12: pause wins
    rs = ok && !pz && is_resume(flow_mode, rx_data);
    sp = ok && spec_en && rx_data == m_chr[3];
    m_wr = rx_valid && !pz && !rs;
    if (rx_valid) m_wdata = rx_data;
    m_spec  = sp || (m_spec && !isr_rd);            // R11
    m_xflag = pz || (m_xflag && !isr_rd);
    if (pz) m_xstate = 1; else if (rs) m_xstate = 0;
    if (reg_we) m_chr[reg_addr] = reg_wdata;        // R2
    @(posedge clk); #1;
    chk("R3 fifo_wr", fifo_wr, m_wr);
    if (m_wr) chk("R3 fifo_wdata", fifo_wdata, m_wdata);
    chk("R5 spec_flag", spec_flag, m_spec);
    chk("R6 xoff_flag", xoff_flag, m_xflag);
    chk("R6 xoff_state", xoff_state, m_xstate);
    chk("R10 irq_spec", irq_spec, m_spec && ie_spec);
    chk("R10 irq_xoff", irq_xoff, m_xflag && ie_xoff);
    rx_valid = 0; reg_we = 0; isr_rd = 0; rx_err = 0;
  endtask

  task automatic wreg(logic [1:0] a, logic [DW-1:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; tick();
  endtask

  task automatic rx(logic [DW-1:0] d, bit e = 0, bit rd = 0);
    rx_valid = 1; rx_data = d; rx_err = e; isr_rd = rd; tick();
  endtask

  task automatic rd_isr();
    isr_rd = 1; tick();
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED);
    for (int i = 0; i < 4; i++) m_chr[i] = 0;
    m_wr = 0; m_spec = 0; m_xflag = 0; m_xstate = 0; m_wdata = 0;
    #(PERIOD * 3 + 1);
    // R1 reset state
    chk("R1 fifo_wr", fifo_wr, 0); chk("R1 spec_flag", spec_flag, 0);
    chk("R1 xoff_state", xoff_state, 0); chk("R1 irq_xoff", irq_xoff, 0);
    rst_n = 1;
    @(posedge clk); #1;
    // R1 characters reset to zero: mode 10 and byte 00 is a pause
    flow_mode = 2'b10; rx(8'h00);
    chk("R1 zero pause", xoff_state, 1);
    rx(8'h00);
    flow_mode = 2'b00; rd_isr();
    // R2 register map
    wreg(0, 8'h11); wreg(1, 8'h13); wreg(2, 8'h22); wreg(3, 8'hA5);
    flow_mode = 2'b10; rx(8'h11);
    chk("R2 resume A", xoff_state, 0);
    rx(8'h22); chk("R2 pause A", xoff_state, 1);
    rx(8'h11);
    // R4 disabled detect
    flow_mode = 2'b00; spec_en = 0; rx(8'hA5);
    chk("R4 no spec", spec_flag, 0); chk("R4 stored", fifo_wr, 1);
    // R5 enabled detect, bit order: 0x01 must not match 0x80
    spec_en = 1; wreg(3, 8'h01); rx(8'h80); chk("R5 bit order", spec_flag, 0);
    wreg(3, 8'hA5);
    rx(8'hA5); chk("R5 spec set", spec_flag, 1); chk("R5 stored", fifo_wdata, 8'hA5);
    // R10 gating
    ie_spec = 0; tick(); chk("R10 gated", irq_spec, 0);
    ie_spec = 1; #0; chk("R10 pass", irq_spec, 1);
    // R11 read clears
    rd_isr(); chk("R11 clear", spec_flag, 0);
    // R11 simultaneous set and read
    rx(8'hA5, 0, 1); chk("R11 set wins", spec_flag, 1);
    rd_isr();
    // R6 pair A independent of special detect
    flow_mode = 2'b10; ie_xoff = 1;
    rx(8'h22); chk("R6 pause swallowed", fifo_wr, 0); chk("R6 irq", irq_xoff, 1);
    rx(8'hA5); chk("R6 spec stored", fifo_wr, 1); chk("R6 spec set", spec_flag, 1);
    rx(8'h11); chk("R6 resume swallowed", fifo_wr, 0); chk("R6 resumed", xoff_state, 0);
    rd_isr();
    // R7 pair B
    flow_mode = 2'b01; rx(8'hA5);
    chk("R7 swallowed", fifo_wr, 0); chk("R7 state", xoff_state, 1);
    chk("R7 spec", spec_flag, 1); chk("R7 xoff irq", irq_xoff, 1);
    // R8 resume B
    rx(8'h13); chk("R8 swallowed", fifo_wr, 0); chk("R8 cleared", xoff_state, 0);
    rd_isr();
    // R9 errored byte
    rx(8'hA5, 1); chk("R9 stored", fifo_wr, 1); chk("R9 no spec", spec_flag, 0);
    chk("R9 no pause", xoff_state, 0);
    // R12 same char as resume and pause
    flow_mode = 2'b10; wreg(0, 8'h22); rx(8'h22); chk("R12 pause wins", xoff_state, 1);
    flow_mode = 2'b11; rx(8'h22); chk("R12 mode 11 stored", fifo_wr, 1);
    flow_mode = 2'b00; rx(8'h22); chk("R12 mode 00 stored", fifo_wr, 1);
    wreg(0, 8'h11);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom % 16;
      flow_mode = 2'($urandom); spec_en = 1'($urandom); ie_spec = 1'($urandom);
      ie_xoff = 1'($urandom);
      if (k < 9) begin
        rx_valid = 1; rx_err = ($urandom % 8) == 0; isr_rd = ($urandom % 6) == 0;
        rx_data = (k < 7) ? m_chr[k % 4] : 8'($urandom);
        tick();
      end else if (k < 10) begin
        reg_we = 1; reg_addr = 2'($urandom); reg_wdata = 8'($urandom % 4 + 8'h20); tick();
      end else begin
        isr_rd = ($urandom % 3) == 0; tick();
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule